// File: doc/BRIEF.md
# Reset Source Status Capture Unit

This unit merges every reset request of a small controller into one system reset. It also keeps an 8-bit record of what caused the most recent reset, and software reads that record as a status byte. The requests come from several places: a power-on detector, a gated low-voltage detector, an active-low external reset pin, a gated watchdog timeout, an illegal-opcode condition, and an illegal-address detector. The illegal-opcode condition is built from a raw flag and two gated instruction cases. The illegal-address detector watches valid bus accesses that land in two fixed address gaps.

Power-on clears the unit asynchronously. The other sources pass through a two-flop synchronizer, or through one register when they are bus decodes. While any request is active, the system reset is held, and it stays held for a fixed number of cycles after the last request goes away. The status byte is loaded only at the moment that reset is released, from every cause seen during the reset window. The low-voltage and power-on causes follow their own rules for bit 7.

A write to the status address produces a one-cycle watchdog service pulse and has no other effect. All pins are plain control and status levels, with no handshake.

Top module: `rst_cause_unit`

## Requirements
- R1: Status bit positions are fixed: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 1 low-voltage. Bits 2 and 0 always read 0.
- R2: While `por_i` is 1, `status_o` reads 8'h82 at once, without waiting for a clock edge, and `sys_rst_o` is 1. After `por_i` falls, `sys_rst_o` stays 1 until the HOLD-th rising edge, and `status_o` is still 8'h82 after release.
- R3: A low-voltage reset needs both `lvd_i` and `lvd_rst_en_i` at 1. At its release, bit 7 keeps its previous value, bit 1 becomes 1 and every other bit becomes 0. This result wins over any other cause seen in the same reset window. `lvd_i` alone has no effect.
- R4: For any reset without a power-on or low-voltage cause, bits 6, 5, 4 and 3 at release are each 1 exactly when their source was active at some point between the start of the reset and its release. Bits 7 and 1 are 0.
- R5: `wdog_timeout_i` causes a reset only while `wdog_en_i` is 1. Otherwise it has no effect on `sys_rst_o` or `status_o`.
- R6: A valid access (read or write) to any address in 0x0440..0x17FF or in 0x1834..0xBFFF, both ends included, raises an illegal-address reset. No other address does, including the register holes at 0x1800..0x1833.
- R7: Each cycle with `bus_valid_i`=1, `bus_write_i`=1 and `bus_addr_i`=STATUS_ADDR (default 0x1800) gives `wdog_clear_o`=1 in the following cycle. A read of that address gives no pulse, and neither does a write to any other address. `status_o` does not change.
- R8: The illegal-opcode cause is `bad_opcode_i`, OR (`stop_exec_i` AND NOT `stop_allow_i`), OR (`bgnd_exec_i` AND NOT `dbg_allow_i`).
- R9: `sys_rst_o` falls on the HOLD-th rising edge after the last edge at which an internal request was seen. `status_o` changes only at that release.
- R10: A pin or flag level change reaches `sys_rst_o` after exactly two rising edges. An illegal bus access reaches it after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on detect, active high, asynchronous |
| lvd_i | input | 1 | Low-voltage detect level |
| lvd_rst_en_i | input | 1 | Lets low-voltage detect cause a reset |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdog_timeout_i | input | 1 | Watchdog timeout level |
| wdog_en_i | input | 1 | Lets watchdog timeout cause a reset |
| bad_opcode_i | input | 1 | Unimplemented opcode seen |
| stop_exec_i | input | 1 | Stop instruction executed |
| stop_allow_i | input | 1 | Stop instruction permitted |
| bgnd_exec_i | input | 1 | Background-debug instruction executed |
| dbg_allow_i | input | 1 | Background-debug entry permitted |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | Bus access is a write |
| bus_addr_i | input | AW | Bus address |
| sys_rst_o | output | 1 | Combined system reset, active high |
| status_o | output | 8 | Reset cause status byte |
| wdog_clear_o | output | 1 | One-cycle watchdog service pulse |

## Verification
The bench builds the unit with HOLD=4 and leaves the address gaps and the status address at their defaults. The short hold makes each reset cost only a few cycles. That brings within reach a sweep of all 1024 combinations of the ten synchronized inputs, each run to its release and checked against an arithmetic model of the status byte, including the bit 7 history. It also allows a pass over the whole address space at a 64-address stride with varying low bits, plus every address within three of each gap edge.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned BIT_POR  = 7;
  localparam int unsigned BIT_PIN  = 6;
  localparam int unsigned BIT_WDG  = 5;
  localparam int unsigned BIT_ILOP = 4;
  localparam int unsigned BIT_ILAD = 3;
  localparam int unsigned BIT_LVD  = 1;

  // synchronizer lane map
  localparam int unsigned S_LVD    = 0;
  localparam int unsigned S_LVDEN  = 1;
  localparam int unsigned S_PIN    = 2;
  localparam int unsigned S_WTO    = 3;
  localparam int unsigned S_WEN    = 4;
  localparam int unsigned S_BADOP  = 5;
  localparam int unsigned S_STOP   = 6;
  localparam int unsigned S_STOPOK = 7;
  localparam int unsigned S_BGND   = 8;
  localparam int unsigned S_DBGOK  = 9;
  localparam int unsigned NSYNC    = 10;

  typedef struct packed {
    logic por;
    logic pin;
    logic wdg;
    logic ilop;
    logic ilad;
    logic lvd;
  } cause_t;

  typedef enum logic [1:0] {
    CAP_POWER = 2'd0,
    CAP_LOWV  = 2'd1,
    CAP_EVENT = 2'd2
  } cap_kind_t;

  localparam cause_t POR_ONLY = '{por: 1'b1, default: 1'b0};

  function automatic logic [STAT_W-1:0] encode_status(cap_kind_t kind, cause_t c, logic keep_por);
    logic [STAT_W-1:0] v;
    v = '0;
    case (kind)
      CAP_POWER: begin
        v[BIT_POR] = 1'b1;
        v[BIT_LVD] = 1'b1;
      end
      CAP_LOWV: begin
        v[BIT_POR] = keep_por;
        v[BIT_LVD] = 1'b1;
      end
      default: begin
        v[BIT_PIN]  = c.pin;
        v[BIT_WDG]  = c.wdg;
        v[BIT_ILOP] = c.ilop;
        v[BIT_ILAD] = c.ilad;
      end
    endcase
    return v;
  endfunction
endpackage

// File: rtl/rcu_sync.sv
module rcu_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/rcu_addr_check.sv
module rcu_addr_check #(
  parameter int unsigned          AW          = 16,
  parameter int unsigned          NGAP        = 2,
  parameter logic [NGAP*AW-1:0]   GAP_LO      = {16'h1834, 16'h0440},
  parameter logic [NGAP*AW-1:0]   GAP_HI      = {16'hBFFF, 16'h17FF},
  parameter logic [AW-1:0]        STATUS_ADDR = 16'h1800
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  output logic          illegal_q,
  output logic          clear_q
);
  logic [NGAP-1:0] hit;

  for (genvar g = 0; g < NGAP; g++) begin : g_gap
    localparam logic [AW-1:0] LO = GAP_LO[g*AW +: AW];
    localparam logic [AW-1:0] HI = GAP_HI[g*AW +: AW];
    assign hit[g] = (addr >= LO) && (addr <= HI);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      illegal_q <= 1'b0;
      clear_q   <= 1'b0;
    end else begin
      illegal_q <= valid && (|hit);
      clear_q   <= valid && write && (addr == STATUS_ADDR);
    end
  end
endmodule

// File: rtl/rcu_stretch.sv
module rcu_stretch #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic arst,
  input  logic req,
  output logic rst_o,
  output logic release_o
);
  localparam int unsigned   CW   = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt <= LOAD;
    end else if (req) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign rst_o     = req || (cnt != '0);
  assign release_o = !req && (cnt == ONE);
endmodule

// File: rtl/rcu_status.sv
module rcu_status
  import rcu_pkg::*;
(
  input  logic              clk,
  input  logic              arst,
  input  logic              capture,
  input  cause_t            src,
  output logic [STAT_W-1:0] status_o
);
  cause_t            sticky;
  cause_t            acc;
  cap_kind_t         kind;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] nxt;

  always_comb begin
    acc = cause_t'(sticky | src);
    if (acc.por)      kind = CAP_POWER;
    else if (acc.lvd) kind = CAP_LOWV;
    else              kind = CAP_EVENT;
    nxt = encode_status(kind, acc, status_q[BIT_POR]);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      sticky   <= POR_ONLY;
      status_q <= encode_status(CAP_POWER, POR_ONLY, 1'b1);
    end else if (capture) begin
      sticky   <= '0;
      status_q <= nxt;
    end else begin
      sticky   <= acc;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
  import rcu_pkg::*;
#(
  parameter int unsigned        HOLD        = 16,
  parameter int unsigned        AW          = 16,
  parameter int unsigned        NGAP        = 2,
  parameter logic [NGAP*AW-1:0] GAP_LO      = {16'h1834, 16'h0440},
  parameter logic [NGAP*AW-1:0] GAP_HI      = {16'hBFFF, 16'h17FF},
  parameter logic [AW-1:0]      STATUS_ADDR = 16'h1800
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              lvd_i,
  input  logic              lvd_rst_en_i,
  input  logic              ext_rst_n_i,
  input  logic              wdog_timeout_i,
  input  logic              wdog_en_i,
  input  logic              bad_opcode_i,
  input  logic              stop_exec_i,
  input  logic              stop_allow_i,
  input  logic              bgnd_exec_i,
  input  logic              dbg_allow_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [AW-1:0]     bus_addr_i,
  output logic              sys_rst_o,
  output logic [STAT_W-1:0] status_o,
  output logic              wdog_clear_o
);
  logic [NSYNC-1:0] raw;
  logic [NSYNC-1:0] syn;
  logic             ill_q;
  cause_t           live;
  logic             any_req;
  logic             release_p;

  always_comb begin
    raw           = '0;
    raw[S_LVD]    = lvd_i;
    raw[S_LVDEN]  = lvd_rst_en_i;
    raw[S_PIN]    = ~ext_rst_n_i;
    raw[S_WTO]    = wdog_timeout_i;
    raw[S_WEN]    = wdog_en_i;
    raw[S_BADOP]  = bad_opcode_i;
    raw[S_STOP]   = stop_exec_i;
    raw[S_STOPOK] = stop_allow_i;
    raw[S_BGND]   = bgnd_exec_i;
    raw[S_DBGOK]  = dbg_allow_i;
  end

  rcu_sync #(.W(NSYNC)) u_sync (
    .clk  (clk),
    .arst (por_i),
    .d    (raw),
    .q    (syn)
  );

  rcu_addr_check #(
    .AW          (AW),
    .NGAP        (NGAP),
    .GAP_LO      (GAP_LO),
    .GAP_HI      (GAP_HI),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_addr (
    .clk       (clk),
    .arst      (por_i),
    .valid     (bus_valid_i),
    .write     (bus_write_i),
    .addr      (bus_addr_i),
    .illegal_q (ill_q),
    .clear_q   (wdog_clear_o)
  );

  always_comb begin
    live.por  = 1'b0;
    live.pin  = syn[S_PIN];
    live.wdg  = syn[S_WTO] & syn[S_WEN];
    live.ilop = syn[S_BADOP]
              | (syn[S_STOP] & ~syn[S_STOPOK])
              | (syn[S_BGND] & ~syn[S_DBGOK]);
    live.ilad = ill_q;
    live.lvd  = syn[S_LVD] & syn[S_LVDEN];
    any_req   = |live;
  end

  rcu_stretch #(.HOLD(HOLD)) u_hold (
    .clk       (clk),
    .arst      (por_i),
    .req       (any_req),
    .rst_o     (sys_rst_o),
    .release_o (release_p)
  );

  rcu_status u_stat (
    .clk      (clk),
    .arst     (por_i),
    .capture  (release_p),
    .src      (live),
    .status_o (status_o)
  );
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
  parameter int unsigned        AW          = 16,
  parameter int unsigned        NGAP        = 2,
  parameter logic [NGAP*AW-1:0] GAP_LO      = {16'h1834, 16'h0440},
  parameter logic [NGAP*AW-1:0] GAP_HI      = {16'hBFFF, 16'h17FF},
  parameter logic [AW-1:0]      STATUS_ADDR = 16'h1800
) (
  input logic          clk,
  input logic          por_i,
  input logic          ext_rst_n_i,
  input logic          bus_valid_i,
  input logic          bus_write_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          sys_rst_o,
  input logic [7:0]    status_o,
  input logic          wdog_clear_o
);
  logic [1:0] up;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)          up <= 2'd0;
    else if (up != 2'd3) up <= up + 2'd1;
  end

  function automatic logic in_gap(input logic [AW-1:0] a);
    logic r;
    r = 1'b0;
    for (int g = 0; g < NGAP; g++) begin
      if (a >= GAP_LO[g*AW +: AW] && a <= GAP_HI[g*AW +: AW]) r = 1'b1;
    end
    return r;
  endfunction

  p_spare_bits_zero_r1: assert property (@(posedge clk) disable iff (por_i)
    (status_o[2] == 1'b0) && (status_o[0] == 1'b0));

  p_power_implies_lowv_r2: assert property (@(posedge clk) disable iff (por_i)
    status_o[7] |-> status_o[1]);

  p_bad_access_resets_r6: assert property (@(posedge clk) disable iff (por_i)
    (bus_valid_i && in_gap(bus_addr_i)) |=> sys_rst_o);

  p_clear_follows_write_r7: assert property (@(posedge clk) disable iff (por_i)
    wdog_clear_o |-> $past(bus_valid_i && bus_write_i && (bus_addr_i == STATUS_ADDR)));

  p_status_moves_at_release_r9: assert property (@(posedge clk) disable iff (por_i)
    !$stable(status_o) |-> $past(sys_rst_o));

  p_pin_two_edges_r10: assert property (@(posedge clk) disable iff (por_i)
    ((up == 2'd3) && $past(!ext_rst_n_i, 2)) |-> sys_rst_o);
endmodule

bind rst_cause_unit rcu_checker #(
  .AW          (AW),
  .NGAP        (NGAP),
  .GAP_LO      (GAP_LO),
  .GAP_HI      (GAP_HI),
  .STATUS_ADDR (STATUS_ADDR)
) u_chk (
  .clk          (clk),
  .por_i        (por_i),
  .ext_rst_n_i  (ext_rst_n_i),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .sys_rst_o    (sys_rst_o),
  .status_o     (status_o),
  .wdog_clear_o (wdog_clear_o)
);

// File: tb/rst_cause_unit_tb.sv
module rst_cause_unit_tb;
  localparam int unsigned HOLD = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        por, lvd, lvd_en, ext_n, wto, wen, badop, stp, stp_ok, bg, dbg_ok, bv, bw;
  logic [15:0] ba;
  logic        sys_rst;
  logic [7:0]  status;
  logic        wclr;

  int tests = 0;
  int fails = 0;
  logic [7:0] model;

  rst_cause_unit #(.HOLD(HOLD)) u_dut (
    .clk            (clk),
    .por_i          (por),
    .lvd_i          (lvd),
    .lvd_rst_en_i   (lvd_en),
    .ext_rst_n_i    (ext_n),
    .wdog_timeout_i (wto),
    .wdog_en_i      (wen),
    .bad_opcode_i   (badop),
    .stop_exec_i    (stp),
    .stop_allow_i   (stp_ok),
    .bgnd_exec_i    (bg),
    .dbg_allow_i    (dbg_ok),
    .bus_valid_i    (bv),
    .bus_write_i    (bw),
    .bus_addr_i     (ba),
    .sys_rst_o      (sys_rst),
    .status_o       (status),
    .wdog_clear_o   (wclr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lvd = 0; lvd_en = 0; ext_n = 1; wto = 0; wen = 0; badop = 0;
    stp = 0; stp_ok = 1; bg = 0; dbg_ok = 1; bv = 0; bw = 0; ba = '0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (sys_rst && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic bit is_gap(input logic [15:0] a);
    return (a >= 16'h0440 && a <= 16'h17FF) || (a >= 16'h1834 && a <= 16'hBFFF);
  endfunction

  task automatic do_por();
    int n;
    @(negedge clk);
    por = 1;
    #1;
    chk(status == 8'h82, "R2 status during power-on", status, 8'h82);
    chk(sys_rst == 1'b1, "R2 reset during power-on", sys_rst, 1);
    repeat (2) @(negedge clk);
    por = 0;
    @(negedge clk);
    count_high(n);
    chk(n == HOLD - 1, "R2 hold after power-on", n, HOLD - 1);
    chk(status == 8'h82, "R2 status after power-on", status, 8'h82);
    model = 8'h82;
  endtask

  task automatic apply_combo(input logic [9:0] b);
    int   n;
    bit   seen, any, lvr, wdr, ilop;
    logic [7:0] exp;
    string tag;
    @(negedge clk);
    lvd = b[0]; lvd_en = b[1]; ext_n = ~b[2]; wto = b[3]; wen = b[4];
    badop = b[5]; stp = b[6]; stp_ok = b[7]; bg = b[8]; dbg_ok = b[9];
    repeat (4) @(negedge clk);
    seen = sys_rst;
    idle();
    @(negedge clk);
    count_high(n);
    lvr  = b[0] & b[1];
    wdr  = b[3] & b[4];
    ilop = b[5] | (b[6] & ~b[7]) | (b[8] & ~b[9]);
    any  = lvr | b[2] | wdr | ilop;
    if (lvr)      exp = {model[7], 7'b0000010};
    else if (any) exp = {1'b0, b[2], wdr, ilop, 4'b0000};
    else          exp = model;
    if (lvr)       tag = "R3 low-voltage capture";
    else if (ilop) tag = "R8 illegal opcode";
    else if (wdr)  tag = "R5 watchdog";
    else if (any)  tag = "R4 pin capture";
    else           tag = "R3,R5 gated source ignored";
    chk((seen == any) && (n == (any ? HOLD + 1 : 0)) && (status == exp), tag,
        {15'd0, seen, n[7:0], status}, {15'd0, any, 8'(any ? HOLD + 1 : 0), exp});
    chk((status[2] == 1'b0) && (status[0] == 1'b0), "R1 spare bits", status, exp);
    model = exp;
  endtask

  task automatic access(input logic [15:0] a);
    int n;
    bit ill;
    logic [7:0] exp;
    @(negedge clk);
    bv = 1; bw = 0; ba = a;
    @(negedge clk);
    bv = 0;
    count_high(n);
    ill = is_gap(a);
    exp = ill ? 8'h08 : model;
    chk((n == (ill ? HOLD + 1 : 0)) && (status == exp), "R6 address sweep",
        {a, n[7:0], status}, {a, 8'(ill ? HOLD + 1 : 0), exp});
    model = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    idle();
    por = 1;
    repeat (3) @(negedge clk);
    chk(status == 8'h82, "R2 reset state", status, 8'h82);
    chk(sys_rst == 1'b1, "R2 reset asserted", sys_rst, 1);
    chk(wclr == 1'b0, "R7 no pulse in reset", wclr, 0);
    por = 0;
    @(negedge clk);
    count_high(n);
    chk(n == HOLD - 1, "R2 first hold", n, HOLD - 1);
    model = 8'h82;

    // pin latency and status held during reset
    @(negedge clk);
    ext_n = 0;
    @(negedge clk);
    chk(sys_rst == 1'b0, "R10 one edge not enough", sys_rst, 0);
    @(negedge clk);
    chk(sys_rst == 1'b1, "R10 second edge", sys_rst, 1);
    chk(status == model, "R9 status held during reset", status, model);
    repeat (2) @(negedge clk);
    ext_n = 1;
    @(negedge clk);
    count_high(n);
    chk(n == HOLD + 1, "R9 hold length", n, HOLD + 1);
    chk(status == 8'h40, "R4 pin cause", status, 8'h40);
    model = 8'h40;

    // watchdog service writes
    @(negedge clk);
    bv = 1; bw = 1; ba = 16'h1800;
    @(negedge clk);
    chk(wclr == 1'b1, "R7 first pulse", wclr, 1);
    @(negedge clk);
    chk(wclr == 1'b1, "R7 back-to-back pulse", wclr, 1);
    bv = 0;
    @(negedge clk);
    chk(wclr == 1'b0, "R7 pulse ends", wclr, 0);
    chk((status == model) && !sys_rst, "R7 status untouched", {sys_rst, status}, {1'b0, model});
    bv = 1; bw = 0; ba = 16'h1800;
    @(negedge clk);
    chk(wclr == 1'b0, "R7 read gives no pulse", wclr, 0);
    bw = 1; ba = 16'h1833;
    @(negedge clk);
    chk(!wclr && !sys_rst, "R7,R6 hole write", {wclr, sys_rst}, 0);
    bv = 0; bw = 0;
    repeat (2) @(negedge clk);

    // power-on again in mid-run, then all source combinations
    do_por();
    for (int c = 0; c < 1024; c++) apply_combo(10'(c));

    // causes accumulate over the reset window
    @(negedge clk);
    bv = 1; ba = 16'h2000;
    @(negedge clk);
    bv = 0; badop = 1;
    repeat (3) @(negedge clk);
    badop = 0;
    @(negedge clk);
    count_high(n);
    chk(status == 8'h18, "R4 sticky causes", status, 8'h18);
    model = 8'h18;

    // address space
    for (int i = 0; i < 1024; i++) access(16'(i * 64 + (i % 64)));
    begin
      logic [15:0] edges [7];
      edges = '{16'h0440, 16'h17FF, 16'h1800, 16'h1834, 16'hBFFF, 16'hC000, 16'hFFFF};
      for (int e = 0; e < 7; e++)
        for (int d = -3; d <= 3; d++) access(16'(int'(edges[e]) + d));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule